// File: doc/BRIEF.md
# Event-Triggered Delay Channel

One channel of a timing receiver. It watches a stream of 32-bit event frames. A frame that equals a programmed value, in the bit positions that a mask selects, loads a 22-bit delay. Once a chosen start condition occurs, the channel counts that delay on edges of a selected clock. It then drives an output pulse whose width and polarity are programmed. It can also raise a one-cycle interrupt.

Two further programmed frame values switch the channel on and off. While the channel is off, edges of the selected clock are ignored, so no output is produced. A typical chip instantiates many channels side by side. The output of one channel feeds the `prev_out` input of the next, so channels can be chained.

The frame input is a valid/ready stream that never applies back-pressure. `frame_ready` is held high, so every cycle with `frame_valid` high consumes one frame. A producer must therefore never rely on holding a frame to retry it. The configuration pins are static levels and should only change while the channel is idle.

Top module: `evd_delay_channel`

## Requirements
- R1: A frame with `frame_valid` high triggers when `((frame_data ^ cfg_trig_value) & cfg_trig_mask) == 0`. A mask bit of 1 means the bit is compared and a mask bit of 0 means the bit is a wildcard. A frame that differs in any compared bit produces no pulse.
- R2: Take the main clock and `cfg_start_src` = 0 (start at load). If the trigger is accepted at clock edge e0, the output turns active at edge e0+D, where D is `cfg_delay`. A delay of 0 acts as 1, so a delay of 1 fires on the first counted edge after the start.
- R3: The pulse lasts `cfg_width` main-clock cycles, and a width of 0 acts as 1. The inactive output level is `cfg_invert` and the active level is its complement.
- R4: When `cfg_irq_en` is 1, `irq` is high for exactly the one cycle in which the pulse begins. It stays low otherwise.
- R5: `cfg_start_src` selects what starts the count after a load. Code 0 starts at the load itself. Code 1 starts on a rising edge of `prev_out`. Code 2 starts on a rising edge of `ext_start`. Code 3 starts on the next matching frame. With codes 1 to 3, counting begins at the edge where the start condition is seen.
- R6: `cfg_clk_src` selects which edges are counted. Code 0 or 3 counts every main-clock cycle. Code 1 counts rising edges of `prev_out`. Code 2 counts rising edges of `ext_clk`, and the pulse begins at the edge where the D-th rising edge is seen.
- R7: With `cfg_mode` = 1 (multi), the delay reloads after every pulse, so pulses repeat every D counted edges. Asserting `stop` for one cycle returns the channel to idle.
- R8: With `cfg_mode` = 2 (burst), the delay reloads after a pulse only while the start level is high. The start level is `prev_out` when `cfg_start_src` is 1 and `ext_start` otherwise. A pulse taken with the level low ends the run. Modes 0 and 3 mean once: one pulse, then idle.
- R9: A matching frame is ignored while the channel is armed or counting, and also while an output pulse is still active.
- R10: A frame equal to `cfg_disable_code` turns the channel off, and a frame equal to `cfg_enable_code` turns it on. The channel is on after reset. While the channel is off, counted edges neither advance the delay nor fire. Counting resumes from where it stopped once the channel is on again.
- R11: `frame_ready` is always 1, so the channel exerts no back-pressure.
- R12: After reset the channel is idle, `irq` is 0 and `pulse_out` equals `cfg_invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | Event frame present |
| frame_ready | output | 1 | Always 1 |
| frame_data | input | 32 | Event frame |
| cfg_trig_value | input | 32 | Trigger compare value |
| cfg_trig_mask | input | 32 | 1 = bit compared, 0 = wildcard |
| cfg_enable_code | input | 32 | Frame value that turns the channel on |
| cfg_disable_code | input | 32 | Frame value that turns the channel off |
| cfg_start_src | input | 2 | 0 load, 1 prev_out, 2 ext_start, 3 next match |
| cfg_clk_src | input | 2 | 0/3 main, 1 prev_out, 2 ext_clk |
| cfg_mode | input | 2 | 0/3 once, 1 multi, 2 burst |
| cfg_delay | input | 22 | Delay in counted edges |
| cfg_width | input | 16 | Pulse width in main-clock cycles |
| cfg_invert | input | 1 | Output polarity |
| cfg_irq_en | input | 1 | Interrupt enable |
| prev_out | input | 1 | Output of the previous channel |
| ext_start | input | 1 | External start input |
| ext_clk | input | 1 | External clock or level flag |
| stop | input | 1 | Returns the channel to idle |
| pulse_out | output | 1 | Output pulse |
| irq | output | 1 | Interrupt, one cycle per pulse |

## Verification
The start of the pulse is due D main-clock edges after the edge that accepts the frame or start condition. With `ext_clk` as the counted source, it is due at the edge that samples the D-th rising edge. The pulse then stays active for exactly W edges, and `irq` appears in the same cycle as the start of the pulse. The bench drives inputs at falling edges and samples one falling edge after each rising edge. It counts those samples from the accepting edge, so each measured index equals the number of registered edges passed. Where a stimulus should have no effect, the bench watches the output over a window longer than delay plus width.

// File: rtl/evd_pkg.sv
`timescale 1ns/1ps
package evd_pkg;
  localparam int FRAME_W = 32;
  localparam int DELAY_W = 22;
  localparam int WIDTH_W = 16;

  typedef enum logic [1:0] {
    START_LOAD  = 2'd0,
    START_PREV  = 2'd1,
    START_EXT   = 2'd2,
    START_EVENT = 2'd3
  } start_src_t;

  typedef enum logic [1:0] {
    CLK_MAIN     = 2'd0,
    CLK_PREV     = 2'd1,
    CLK_EXT      = 2'd2,
    CLK_MAIN_ALT = 2'd3
  } clk_src_t;

  typedef enum logic [1:0] {
    MODE_ONCE     = 2'd0,
    MODE_MULTI    = 2'd1,
    MODE_BURST    = 2'd2,
    MODE_ONCE_ALT = 2'd3
  } mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2
  } state_t;
endpackage

// File: rtl/evd_frame_match.sv
`timescale 1ns/1ps
module evd_frame_match #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [FW-1:0] data,
  input  logic [FW-1:0] trig_value,
  input  logic [FW-1:0] trig_mask,
  input  logic [FW-1:0] enable_code,
  input  logic [FW-1:0] disable_code,
  output logic          trig_hit,
  output logic          enabled
);
  logic [FW-1:0] diff;

  assign diff     = (data ^ trig_value) & trig_mask;
  assign trig_hit = valid && (diff == '0);

  // Off-code wins if both codes are programmed equal.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      enabled <= 1'b1;
    else if (valid && data == disable_code)
      enabled <= 1'b0;
    else if (valid && data == enable_code)
      enabled <= 1'b1;
  end
endmodule

// File: rtl/evd_edge_select.sv
`timescale 1ns/1ps
module evd_edge_select
  import evd_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prev_out,
  input  logic       ext_start,
  input  logic       ext_clk,
  input  clk_src_t   clk_src,
  input  start_src_t start_src,
  output logic       tick,
  output logic       start_edge,
  output logic       start_level
);
  localparam int I_PREV = 0;
  localparam int I_XST  = 1;
  localparam int I_XCK  = 2;

  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] rise;

  assign raw = {ext_clk, ext_start, prev_out};

  for (genvar i = 0; i < NSRC; i++) begin : g_edge
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= raw[i];
    end
    assign rise[i] = raw[i] & ~q;
  end

  always_comb begin
    case (clk_src)
      CLK_PREV: tick = rise[I_PREV];
      CLK_EXT:  tick = rise[I_XCK];
      default:  tick = 1'b1;
    endcase
    case (start_src)
      START_PREV: start_edge = rise[I_PREV];
      START_EXT:  start_edge = rise[I_XST];
      default:    start_edge = 1'b0;
    endcase
    start_level = (start_src == START_PREV) ? raw[I_PREV] : raw[I_XST];
  end
endmodule

// File: rtl/evd_counter.sv
`timescale 1ns/1ps
module evd_counter
  import evd_pkg::*;
#(
  parameter int DW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cfg_delay,
  input  start_src_t    start_src,
  input  mode_t         mode,
  input  logic          trig_hit,
  input  logic          pulse_busy,
  input  logic          enabled,
  input  logic          tick,
  input  logic          start_edge,
  input  logic          start_level,
  input  logic          stop,
  output logic          fire,
  output state_t        state,
  output logic [DW-1:0] count
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] dly_eff;
  logic          counted;
  logic          start_go;
  logic          reload;

  assign dly_eff  = (cfg_delay == '0) ? ONE : cfg_delay;
  assign counted  = tick && enabled;
  assign fire     = (state == ST_COUNT) && counted && (count == ONE) && !stop;
  assign start_go = (start_src == START_EVENT) ? trig_hit : start_edge;

  always_comb begin
    case (mode)
      MODE_MULTI: reload = 1'b1;
      MODE_BURST: reload = start_level;
      default:    reload = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      count <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (trig_hit && !pulse_busy) begin
            count <= dly_eff;
            state <= (start_src == START_LOAD) ? ST_COUNT : ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (stop)          state <= ST_IDLE;
          else if (start_go) state <= ST_COUNT;
        end
        ST_COUNT: begin
          if (stop) begin
            state <= ST_IDLE;
          end else if (counted) begin
            if (count == ONE) begin
              if (reload) count <= dly_eff;
              else        state <= ST_IDLE;
            end else begin
              count <= count - ONE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evd_pulse.sv
`timescale 1ns/1ps
module evd_pulse #(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [WW-1:0] cfg_width,
  input  logic          cfg_invert,
  input  logic          cfg_irq_en,
  output logic          pulse_out,
  output logic          irq,
  output logic          busy,
  output logic [WW-1:0] remain
);
  logic [WW-1:0] wid_eff;

  assign wid_eff   = (cfg_width == '0) ? WW'(1) : cfg_width;
  assign busy      = (remain != '0);
  assign pulse_out = busy ^ cfg_invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= fire && cfg_irq_en;
      if (fire)      remain <= wid_eff;
      else if (busy) remain <= remain - WW'(1);
    end
  end
endmodule

// File: rtl/evd_delay_channel.sv
`timescale 1ns/1ps
module evd_delay_channel
  import evd_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_W,
  parameter int DELAY_BITS = DELAY_W,
  parameter int WIDTH_BITS = WIDTH_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_valid,
  output logic                  frame_ready,
  input  logic [FRAME_BITS-1:0] frame_data,
  input  logic [FRAME_BITS-1:0] cfg_trig_value,
  input  logic [FRAME_BITS-1:0] cfg_trig_mask,
  input  logic [FRAME_BITS-1:0] cfg_enable_code,
  input  logic [FRAME_BITS-1:0] cfg_disable_code,
  input  logic [1:0]            cfg_start_src,
  input  logic [1:0]            cfg_clk_src,
  input  logic [1:0]            cfg_mode,
  input  logic [DELAY_BITS-1:0] cfg_delay,
  input  logic [WIDTH_BITS-1:0] cfg_width,
  input  logic                  cfg_invert,
  input  logic                  cfg_irq_en,
  input  logic                  prev_out,
  input  logic                  ext_start,
  input  logic                  ext_clk,
  input  logic                  stop,
  output logic                  pulse_out,
  output logic                  irq
);
  logic                  trig_hit;
  logic                  enabled;
  logic                  tick;
  logic                  start_edge;
  logic                  start_level;
  logic                  fire;
  logic                  pulse_busy;
  state_t                state;
  logic [DELAY_BITS-1:0] count;
  logic [WIDTH_BITS-1:0] remain;

  assign frame_ready = 1'b1;

  evd_frame_match #(.FW(FRAME_BITS)) u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid        (frame_valid),
    .data         (frame_data),
    .trig_value   (cfg_trig_value),
    .trig_mask    (cfg_trig_mask),
    .enable_code  (cfg_enable_code),
    .disable_code (cfg_disable_code),
    .trig_hit     (trig_hit),
    .enabled      (enabled)
  );

  evd_edge_select #(.NSRC(3)) u_edges (
    .clk         (clk),
    .rst_n       (rst_n),
    .prev_out    (prev_out),
    .ext_start   (ext_start),
    .ext_clk     (ext_clk),
    .clk_src     (clk_src_t'(cfg_clk_src)),
    .start_src   (start_src_t'(cfg_start_src)),
    .tick        (tick),
    .start_edge  (start_edge),
    .start_level (start_level)
  );

  evd_counter #(.DW(DELAY_BITS)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_delay   (cfg_delay),
    .start_src   (start_src_t'(cfg_start_src)),
    .mode        (mode_t'(cfg_mode)),
    .trig_hit    (trig_hit),
    .pulse_busy  (pulse_busy),
    .enabled     (enabled),
    .tick        (tick),
    .start_edge  (start_edge),
    .start_level (start_level),
    .stop        (stop),
    .fire        (fire),
    .state       (state),
    .count       (count)
  );

  evd_pulse #(.WW(WIDTH_BITS)) u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .cfg_width  (cfg_width),
    .cfg_invert (cfg_invert),
    .cfg_irq_en (cfg_irq_en),
    .pulse_out  (pulse_out),
    .irq        (irq),
    .busy       (pulse_busy),
    .remain     (remain)
  );
endmodule

// File: rtl/evd_delay_channel_chk.sv
`timescale 1ns/1ps
module evd_delay_channel_chk
  import evd_pkg::*;
#(
  parameter int DW = 22,
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input state_t        state,
  input logic [DW-1:0] count,
  input logic          enabled,
  input logic          stop,
  input logic          fire,
  input logic [WW-1:0] remain,
  input logic          irq,
  input logic          trig_hit
);
  // R2: a counting channel never holds an exhausted delay
  p_count_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COUNT) |-> (count != '0));

  // R10: while off, the delay holds its value
  p_hold_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COUNT && !enabled && !stop) |=> $stable(count));

  // R3: every fire produces at least one active cycle
  p_width_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (remain != '0));

  // R4: interrupt only in the cycle after a fire
  p_irq_after_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(fire));

  // R9: a match during an active pulse leaves the channel idle
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && remain != '0 && trig_hit) |=> (state == ST_IDLE));
endmodule

bind evd_delay_channel evd_delay_channel_chk #(.DW(DELAY_BITS), .WW(WIDTH_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state    (state),
  .count    (count),
  .enabled  (enabled),
  .stop     (stop),
  .fire     (fire),
  .remain   (remain),
  .irq      (irq),
  .trig_hit (trig_hit)
);

// File: tb/evd_delay_channel_test.sv
`timescale 1ns/1ps
module evd_delay_channel_test;
  localparam logic [31:0] TRIG = 32'h1402_0005;
  localparam logic [31:0] ONC  = 32'h1410_0001;
  localparam logic [31:0] OFFC = 32'h1411_0001;

  typedef struct packed {
    logic [31:0] frame;
    logic [31:0] mask;
    logic [21:0] dly;
    logic [15:0] wid;
    logic        inv;
    logic        hit;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h1402_0005, 32'hFFFF_FFFF, 22'd1,  16'd1, 1'b0, 1'b1},
    '{32'h1402_0005, 32'hFFFF_FFFF, 22'd7,  16'd4, 1'b1, 1'b1},
    '{32'h1402_FFFF, 32'hFFFF_0000, 22'd5,  16'd0, 1'b0, 1'b1},
    '{32'h1403_0005, 32'hFFFF_0000, 22'd3,  16'd2, 1'b0, 1'b0},
    '{32'h1402_0005, 32'hFFFF_FFFF, 22'd0,  16'd3, 1'b0, 1'b1},
    '{32'h9402_0005, 32'h0FFF_FFFF, 22'd12, 16'd6, 1'b1, 1'b1}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        frame_valid = 0;
  logic        frame_ready;
  logic [31:0] frame_data = '0;
  logic [31:0] cfg_trig_mask = '1;
  logic [1:0]  cfg_start_src = 0, cfg_clk_src = 0, cfg_mode = 0;
  logic [21:0] cfg_delay = 22'd1;
  logic [15:0] cfg_width = 16'd1;
  logic        cfg_invert = 0, cfg_irq_en = 0;
  logic        prev_out = 0, ext_start = 0, ext_clk = 0, stop = 0;
  logic        pulse_out, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evd_delay_channel uut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_ready(frame_ready),
    .frame_data(frame_data), .cfg_trig_value(TRIG), .cfg_trig_mask(cfg_trig_mask),
    .cfg_enable_code(ONC), .cfg_disable_code(OFFC), .cfg_start_src(cfg_start_src),
    .cfg_clk_src(cfg_clk_src), .cfg_mode(cfg_mode), .cfg_delay(cfg_delay),
    .cfg_width(cfg_width), .cfg_invert(cfg_invert), .cfg_irq_en(cfg_irq_en),
    .prev_out(prev_out), .ext_start(ext_start), .ext_clk(ext_clk), .stop(stop),
    .pulse_out(pulse_out), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] d);
    @(negedge clk);
    frame_data = d;
    frame_valid = 1;
    @(posedge clk);
    #1 frame_valid = 0;
  endtask

  task automatic wait_active(input int maxc, output int at);
    at = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk); @(negedge clk);
      if (pulse_out != cfg_invert) begin at = i; break; end
    end
  endtask

  task automatic measure_width(output int w);
    w = 1;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); @(negedge clk);
      if (pulse_out == cfg_invert) break;
      w++;
    end
  endtask

  task automatic count_active(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (pulse_out != cfg_invert) c++;
    end
  endtask

  task automatic defaults();
    cfg_trig_mask = '1; cfg_start_src = 0; cfg_clk_src = 0; cfg_mode = 0;
    cfg_invert = 0; cfg_irq_en = 0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int at, w, c, first, tot, de, we;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R12 / R11 reset state
    check(pulse_out == 1'b0, "R12 out", pulse_out, 0);
    check(irq == 1'b0, "R12 irq", irq, 0);
    check(frame_ready == 1'b1, "R11 ready", frame_ready, 1);

    // Vector table: R1 mask, R2 delay, R3 width/polarity
    for (int v = 0; v < NV; v++) begin
      cfg_trig_mask = VECS[v].mask;
      cfg_delay = VECS[v].dly;
      cfg_width = VECS[v].wid;
      cfg_invert = VECS[v].inv;
      de = (VECS[v].dly == 0) ? 1 : int'(VECS[v].dly);
      we = (VECS[v].wid == 0) ? 1 : int'(VECS[v].wid);
      @(negedge clk);
      check(pulse_out == VECS[v].inv, "R3 idle level", pulse_out, VECS[v].inv);
      send(VECS[v].frame);
      if (VECS[v].hit) begin
        wait_active(de + 5, at);
        check(at == de, "R2 R1 delay", at, de);
        measure_width(w);
        check(w == we, "R3 width", w, we);
      end else begin
        count_active(de + we + 5, c);
        check(c == 0, "R1 mismatch", c, 0);
      end
      repeat (3) @(posedge clk);
    end
    defaults();

    // R4 interrupt
    cfg_irq_en = 1; cfg_delay = 3; cfg_width = 2;
    send(TRIG);
    wait_active(10, at);
    check(at == 3, "R4 fire", at, 3);
    check(irq == 1'b1, "R4 irq high", irq, 1);
    @(posedge clk); @(negedge clk);
    check(irq == 1'b0, "R4 irq single", irq, 0);
    repeat (4) @(posedge clk);
    defaults();

    // R5 start on prev_out rising edge
    cfg_start_src = 1; cfg_delay = 4; cfg_width = 1;
    send(TRIG);
    count_active(5, c);
    check(c == 0, "R5 armed wait", c, 0);
    @(negedge clk); prev_out = 1;
    @(posedge clk);
    wait_active(10, at);
    check(at == 4, "R5 prev start", at, 4);
    @(negedge clk); prev_out = 0;
    repeat (3) @(posedge clk);

    // R5 start on next matching frame
    cfg_start_src = 3; cfg_delay = 2;
    send(TRIG);
    count_active(8, c);
    check(c == 0, "R5 event armed", c, 0);
    send(TRIG);
    wait_active(10, at);
    check(at == 2, "R5 event start", at, 2);
    repeat (3) @(posedge clk);
    defaults();

    // R6 external clock edges
    cfg_clk_src = 2; cfg_delay = 3; cfg_width = 2;
    send(TRIG);
    for (int k = 1; k <= 3; k++) begin
      repeat (2) @(posedge clk);
      @(negedge clk); ext_clk = 1;
      @(posedge clk); @(negedge clk);
      check((pulse_out != cfg_invert) == (k == 3), "R6 ext edge", k, 3);
      ext_clk = 0;
    end
    repeat (4) @(posedge clk);
    defaults();

    // R7 multi-pulse and stop
    cfg_mode = 1; cfg_delay = 4; cfg_width = 1;
    send(TRIG);
    count_active(20, c);
    check(c == 5, "R7 repeats", c, 5);
    @(negedge clk); stop = 1;
    @(posedge clk); #1 stop = 0;
    repeat (3) @(posedge clk);
    count_active(20, c);
    check(c == 0, "R7 stopped", c, 0);
    defaults();

    // R8 burst while ext_start held (R5 ext start)
    cfg_mode = 2; cfg_start_src = 2; cfg_delay = 3; cfg_width = 1;
    send(TRIG);
    @(negedge clk); ext_start = 1;
    @(posedge clk);
    count_active(12, c);
    check(c == 4, "R8 burst held", c, 4);
    ext_start = 0;
    repeat (8) @(posedge clk);
    count_active(20, c);
    check(c == 0, "R8 burst ended", c, 0);
    defaults();

    // R9 retrigger ignored while counting and during pulse
    cfg_delay = 10; cfg_width = 3;
    send(TRIG);
    first = -1; tot = 0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (pulse_out != cfg_invert) begin tot++; if (first < 0) first = i; end
      frame_data = TRIG;
      frame_valid = (i == 5 || i == 11);
    end
    frame_valid = 0;
    check(first == 10, "R9 first pulse", first, 10);
    check(tot == 3, "R9 single pulse", tot, 3);
    repeat (3) @(posedge clk);

    // R10 disable / enable codes
    cfg_delay = 6; cfg_width = 2;
    send(OFFC);
    send(TRIG);
    count_active(30, c);
    check(c == 0, "R10 disabled", c, 0);
    send(ONC);
    wait_active(20, at);
    check(at == 6, "R10 resumed", at, 6);
    repeat (4) @(posedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule